// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns one parallel byte into an asynchronous serial frame on a single line, `txd_o`. It runs from an oversampling clock that is either 16 or 8 times the bit rate. The `div8_i` input picks the ratio, so one input doubles or halves the bit rate. A frame has a low start bit, then 7 or 8 data bits with the least significant bit first. An odd or even parity bit may follow. The frame ends with one or two high stop bits. With all configuration inputs at 0, the frame has 7 data bits, 1 stop bit and no parity.

A producer offers a byte on `data_i` with `valid_i`. The block takes the byte on a clock edge where `valid_i` and `ready_o` are both high. On that same edge it stores the byte and the five configuration inputs. The frame then runs entirely from those stored values. The inputs may change freely while `busy_o` is high.

The sequencer has five states, left in turn:
- IDLE: the line is high and `ready_o` is high.
- START: IDLE moves here when a byte is accepted.
- DATA: START moves here at the end of its bit time. DATA stays put until the last data bit is done.
- PARITY: DATA moves here at the end of the last data bit, but only when parity is enabled.
- STOP: DATA moves here at the end of the last data bit when parity is disabled. PARITY moves here at the end of its bit time.

STOP returns to IDLE at the end of the last stop bit.

Top module: `async_frame_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `txd_o` is high, `ready_o` is high and `busy_o` is low.
- R2: Every bit of a frame lasts 16 clock cycles when the stored `div8_i` is 0 and 8 cycles when it is 1. A frame of B bits therefore keeps `busy_o` high for exactly 16·B or 8·B cycles.
- R3: The cycle after acceptance begins exactly one start bit, driven low.
- R4: Data bits go out bit 0 first. There are 8 of them when the stored `len8_i` is 1 and 7 (bits 0 to 6) when it is 0.
- R5: When the stored `par_en_i` is 1, one parity bit follows the data bits. It makes the total count of ones odd when `par_odd_i` is 1 and even when it is 0. Only the data bits actually sent are counted, so bit 7 is excluded in a 7-bit frame. When `par_en_i` is 0, no parity bit is sent.
- R6: The frame ends with two high stop bits when the stored `stop2_i` is 1 and one high stop bit when it is 0.
- R7: A byte is accepted only on an edge where `valid_i` and `ready_o` are both high. `ready_o` is low and `busy_o` is high from the cycle after acceptance through the final stop-bit cycle. `valid_i` has no effect while `busy_o` is high.
- R8: `data_i` and the configuration inputs are captured on acceptance. Changing them during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock (16x or 8x the bit rate) |
| rst_n | input | 1 | Asynchronous active-low reset |
| div8_i | input | 1 | 1: 8 clocks per bit; 0: 16 clocks per bit |
| len8_i | input | 1 | 1: 8 data bits; 0: 7 data bits |
| par_en_i | input | 1 | 1: append a parity bit |
| par_odd_i | input | 1 | 1: odd parity; 0: even parity |
| stop2_i | input | 1 | 1: two stop bits; 0: one stop bit |
| data_i | input | DATA_W | Byte to send |
| valid_i | input | 1 | Producer offers `data_i` |
| ready_o | output | 1 | Block can accept a byte this cycle |
| busy_o | output | 1 | A frame is in progress |
| txd_o | output | 1 | Serial line, idles high |

## Verification
The in-line assertions check these properties on every cycle:
- the line is high whenever the block is ready;
- every acceptance is followed at once by a low line;
- the bit counter never passes the stored period;
- the data index stays within the stored length;
- the sequencer only enters through START and only leaves through STOP;
- any bit in PARITY state matches the parity of the stored, masked byte;
- the stored byte and configuration do not move while busy.

Only the bench scenarios can show the shape of the whole frame: the exact length of each bit, the order of the data bits, and where the parity bit sits or that it is absent. The bench sweeps all 32 configurations over several data patterns. In every frame it scrambles the inputs and holds `valid_i` high while busy, to show that neither has any effect.

// File: rtl/aft_pkg.sv
package aft_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_START  = 3'd1,
        ST_DATA   = 3'd2,
        ST_PARITY = 3'd3,
        ST_STOP   = 3'd4
    } aft_state_e;

    typedef struct packed {
        logic div8;
        logic len8;
        logic par_en;
        logic par_odd;
        logic stop2;
    } aft_cfg_t;

    localparam aft_cfg_t AFT_CFG_RESET = '{default: 1'b0};

endpackage

// File: rtl/aft_bit_timer.sv
module aft_bit_timer #(
    parameter int OVS_HI = 16,
    parameter int OVS_LO = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    input  logic run_i,
    input  logic div8_i,
    output logic bit_end_o
);
    localparam int CNT_W = $clog2(OVS_HI);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_cnt;

    assign last_cnt  = div8_i ? CNT_W'(OVS_LO - 1) : CNT_W'(OVS_HI - 1);
    assign bit_end_o = run_i && (cnt_q == last_cnt);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart_i || !run_i) begin
            cnt_q <= '0;
        end else if (bit_end_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    AST_CNT_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (cnt_q <= last_cnt)); // R2

    AST_CNT_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !restart_i) |=> (cnt_q == '0)); // R2

endmodule

// File: rtl/aft_capture.sv
module aft_capture
    import aft_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_i,
    input  aft_cfg_t          cfg_i,
    input  logic [DATA_W-1:0] data_i,
    output aft_cfg_t          cfg_q,
    output logic [DATA_W-1:0] data_q,
    output logic              par_q
);
    logic [DATA_W-1:0] sent_mask;
    logic              par_d;

    assign sent_mask = cfg_i.len8 ? {DATA_W{1'b1}} : {1'b0, {(DATA_W-1){1'b1}}};
    assign par_d     = (^(data_i & sent_mask)) ^ cfg_i.par_odd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q  <= AFT_CFG_RESET;
            data_q <= '0;
            par_q  <= 1'b0;
        end else if (take_i) begin
            cfg_q  <= cfg_i;
            data_q <= data_i;
            par_q  <= par_d;
        end
    end

endmodule

// File: rtl/aft_fsm.sv
module aft_fsm
    import aft_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       accept_i,
    input  logic                       bit_end_i,
    input  logic                       len8_i,
    input  logic                       par_en_i,
    input  logic                       stop2_i,
    output aft_state_e                 state_o,
    output logic [$clog2(DATA_W)-1:0]  idx_o
);
    localparam int IDX_W = $clog2(DATA_W);

    aft_state_e       state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic             stop_q, stop_d;
    logic [IDX_W-1:0] last_idx;

    assign last_idx = len8_i ? IDX_W'(DATA_W - 1) : IDX_W'(DATA_W - 2);
    assign state_o  = state_q;
    assign idx_o    = idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            stop_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            stop_q  <= stop_d;
        end
    end

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        stop_d  = stop_q;
        unique case (state_q)
            ST_IDLE: begin
                idx_d  = '0;
                stop_d = 1'b0;
                if (accept_i) state_d = ST_START;
            end
            ST_START: begin
                if (bit_end_i) state_d = ST_DATA;
            end
            ST_DATA: begin
                if (bit_end_i) begin
                    if (idx_q == last_idx) begin
                        state_d = par_en_i ? ST_PARITY : ST_STOP;
                    end else begin
                        idx_d = idx_q + IDX_W'(1);
                    end
                end
            end
            ST_PARITY: begin
                if (bit_end_i) state_d = ST_STOP;
            end
            ST_STOP: begin
                if (bit_end_i) begin
                    if (stop_q == stop2_i) state_d = ST_IDLE;
                    else                   stop_d  = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    AST_IDX_IN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA) |-> (idx_q <= last_idx)); // R4

    AST_ENTRY_VIA_START: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> (state_q == ST_IDLE || state_q == ST_START)); // R3

    AST_EXIT_VIA_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && state_q != ST_STOP) |=> (state_q != ST_IDLE)); // R6

endmodule

// File: rtl/async_frame_tx.sv
module async_frame_tx
    import aft_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS_HI = 16,
    parameter int OVS_LO = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              div8_i,
    input  logic              len8_i,
    input  logic              par_en_i,
    input  logic              par_odd_i,
    input  logic              stop2_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              valid_i,
    output logic              ready_o,
    output logic              busy_o,
    output logic              txd_o
);
    localparam int IDX_W = $clog2(DATA_W);

    aft_cfg_t          cfg_in, cfg_q;
    logic [DATA_W-1:0] data_q;
    logic              par_q;
    logic              accept;
    logic              bit_end;
    aft_state_e        state;
    logic [IDX_W-1:0]  idx;

    assign cfg_in = '{div8: div8_i, len8: len8_i, par_en: par_en_i,
                      par_odd: par_odd_i, stop2: stop2_i};
    assign accept = valid_i && ready_o;

    aft_capture #(.DATA_W(DATA_W)) u_capture (
        .clk    (clk),
        .rst_n  (rst_n),
        .take_i (accept),
        .cfg_i  (cfg_in),
        .data_i (data_i),
        .cfg_q  (cfg_q),
        .data_q (data_q),
        .par_q  (par_q)
    );

    aft_bit_timer #(.OVS_HI(OVS_HI), .OVS_LO(OVS_LO)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (accept),
        .run_i     (state != ST_IDLE),
        .div8_i    (cfg_q.div8),
        .bit_end_o (bit_end)
    );

    aft_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept_i  (accept),
        .bit_end_i (bit_end),
        .len8_i    (cfg_q.len8),
        .par_en_i  (cfg_q.par_en),
        .stop2_i   (cfg_q.stop2),
        .state_o   (state),
        .idx_o     (idx)
    );

    always_comb begin
        ready_o = (state == ST_IDLE);
        busy_o  = !ready_o;
        unique case (state)
            ST_IDLE:   txd_o = 1'b1;
            ST_START:  txd_o = 1'b0;
            ST_DATA:   txd_o = data_q[idx];
            ST_PARITY: txd_o = par_q;
            ST_STOP:   txd_o = 1'b1;
            default:   txd_o = 1'b1;
        endcase
    end

    logic [DATA_W-1:0] chk_mask;
    assign chk_mask = cfg_q.len8 ? {DATA_W{1'b1}} : {1'b0, {(DATA_W-1){1'b1}}};

    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> txd_o); // R1

    AST_ACCEPT_THEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && ready_o) |=> (!txd_o && busy_o)); // R3

    AST_PARITY_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PARITY) |-> (txd_o == ((^(data_q & chk_mask)) ^ cfg_q.par_odd))); // R5

    AST_CAPTURE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> ($stable(cfg_q) && $stable(data_q))); // R8

endmodule

// File: tb/async_frame_tx_bench.sv
module async_frame_tx_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       div8 = 1'b0, len8 = 1'b0, par_en = 1'b0, par_odd = 1'b0, stop2 = 1'b0;
    logic [7:0] data = 8'h00;
    logic       valid = 1'b0;
    logic       ready, busy, txd;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    async_frame_tx u_async_frame_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .div8_i    (div8),
        .len8_i    (len8),
        .par_en_i  (par_en),
        .par_odd_i (par_odd),
        .stop2_i   (stop2),
        .data_i    (data),
        .valid_i   (valid),
        .ready_o   (ready),
        .busy_o    (busy),
        .txd_o     (txd)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic run_frame(input logic d8, input logic l8, input logic pe,
                             input logic po, input logic s2, input logic [7:0] dat);
        logic exp_b [0:11];
        int   kind  [0:11];
        int   nper, nb, total, k;
        bit   bad_k [0:3];
        int   act_k [0:3];
        int   exp_k [0:3];
        bit   rdy_bad;
        logic [7:0] mask;
        for (int i = 0; i < 4; i++) begin
            bad_k[i] = 0; act_k[i] = 0; exp_k[i] = 0;
        end
        rdy_bad = 0;
        nper = d8 ? 8 : 16;
        nb   = l8 ? 8 : 7;
        mask = l8 ? 8'hFF : 8'h7F;
        k = 0;
        exp_b[k] = 1'b0; kind[k] = 0; k++;
        for (int i = 0; i < nb; i++) begin
            exp_b[k] = dat[i]; kind[k] = 1; k++;
        end
        if (pe) begin
            exp_b[k] = (^(dat & mask)) ^ po; kind[k] = 2; k++;
        end
        exp_b[k] = 1'b1; kind[k] = 3; k++;
        if (s2) begin
            exp_b[k] = 1'b1; kind[k] = 3; k++;
        end
        total = k * nper;

        @(negedge clk);
        div8 = d8; len8 = l8; par_en = pe; par_odd = po; stop2 = s2;
        data = dat; valid = 1'b1;
        chk(ready === 1'b1, "R7", "ready before accept", int'(ready), 1);
        @(posedge clk);
        #2;
        // R8: scramble every captured input; R7: valid stays high while busy
        div8 = ~d8; len8 = ~l8; par_en = ~pe; par_odd = ~po; stop2 = ~s2;
        data = ~dat;
        for (int s = 0; s < total; s++) begin
            int b;
            @(negedge clk);
            b = s / nper;
            if (txd !== exp_b[b] && !bad_k[kind[b]]) begin
                bad_k[kind[b]] = 1;
                act_k[kind[b]] = int'(txd);
                exp_k[kind[b]] = int'(exp_b[b]);
            end
            if (ready !== 1'b0 || busy !== 1'b1) rdy_bad = 1;
            if (s == total - 1) valid = 1'b0;
        end
        chk(!bad_k[0], "R3", "start bit", act_k[0], exp_k[0]);
        chk(!bad_k[1], "R4", "data bits", act_k[1], exp_k[1]);
        chk(!bad_k[2], "R5", "parity bit", act_k[2], exp_k[2]);
        chk(!bad_k[3], "R6", "stop bits / parity absence", act_k[3], exp_k[3]);
        chk(!rdy_bad, "R7", "ready low during frame", int'(rdy_bad), 0);
        chk(!(bad_k[0] || bad_k[1] || bad_k[2] || bad_k[3]), "R8",
            "frame unaffected by mid-frame input changes", 1, 0);
        @(negedge clk);
        chk(ready === 1'b1 && busy === 1'b0, "R2", "ready one cycle after frame of bits*period",
            int'(ready), 1);
        chk(txd === 1'b1, "R1", "line idle after frame", int'(txd), 1);
    endtask

    initial begin
        logic [7:0] pats [0:5];
        pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hA5;
        pats[3] = 8'h5A; pats[4] = 8'h80; pats[5] = 8'h01;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(txd === 1'b1, "R1", "txd after reset", int'(txd), 1);
        chk(ready === 1'b1, "R1", "ready after reset", int'(ready), 1);
        chk(busy === 1'b0, "R1", "busy after reset", int'(busy), 0);
        for (int c = 0; c < 32; c++) begin
            for (int p = 0; p < 6; p++) begin
                run_frame(c[4], c[3], c[2], c[1], c[0], pats[p]);
            end
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 190000, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule